// File: doc/BRIEF.md
# Fractional baud generator

This block produces the timing strobes a UART needs from a single peripheral clock. An integer divisor, given as a low byte and a high byte, sets the basic 16x oversampling period. A fractional stage, controlled by a 4-bit multiplier value and a 4-bit add value, then lowers the average rate by the factor MUL / (MUL + DIVADD). It does this by lengthening some periods by one extra divisor count. The block outputs a one-cycle 16x strobe, a one-cycle bit-rate strobe on every sixteenth 16x strobe, and a flag that reports a configuration the generator cannot run.

Accumulated error never builds up, because an accumulator decides which periods are stretched. Over any run of MUL consecutive periods, exactly DIVADD of them are stretched. New settings are picked up only at a 16x strobe boundary. While the block is halted, settings are picked up on every cycle, so that a valid setting restarts the block at once.

Top module: `frac_baud_gen`

## Requirements
- R1: With divisor D ≥ 2, effective multiplier M and effective add value A ≤ M, every M consecutive 16x strobe intervals add up to exactly D·(M+A) clock cycles, counted from the first strobe after reset. This gives the average rate clk/(16·D)·M/(M+A).
- R2: With the add value 0, the block is a plain divider. The 16x strobe repeats every D cycles, with D = {high byte, low byte}, and the high byte is the upper 8 bits.
- R3: Each strobe is one cycle wide. The bit-rate strobe is high only together with a 16x strobe, and only on every 16th one. With D = 1 and add value 0, the bit-rate strobe repeats every 16 cycles (3.75 Mbit/s from 60 MHz).
- R4: With a nonzero add value and D of 0 or 1, the error flag is high and no strobes are produced. With D = 2, a nonzero add value is legal.
- R5: With D = 0 and add value 0, the error flag is high and no strobes are produced.
- R6: A multiplier value of 0 acts as 1.
- R7: An add value larger than the effective multiplier is clamped to it. Every period is then 2·D (a 50 % reduction).
- R8: While the block is running, changed settings take effect only at the next 16x strobe, and the period in progress completes with the old divisor. While the block is halted by an error, changed settings are loaded on the next clock edge.
- R9: During reset, all outputs are low. After reset is released, the first 16x strobe is high after the D-th rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_lo_i | input | 8 | Integer divisor, low byte |
| div_hi_i | input | 8 | Integer divisor, high byte |
| mul_i | input | 4 | Fractional multiplier value (0 acts as 1) |
| divadd_i | input | 4 | Fractional add value |
| tick16_o | output | 1 | 16x oversampling strobe, one cycle |
| tick_bit_o | output | 1 | Bit-rate strobe, one cycle, every 16th 16x strobe |
| cfg_err_o | output | 1 | Configuration error; strobes suppressed |

## Verification
The properties assume that the settings seen at a 16x strobe are the ones the block loads. This holds because the inputs are sampled only at that edge, so the error checks look one cycle after a strobe and never need input stability at other times. The bench changes settings only on falling edges, and it changes them mid-period in just one scenario, the one that checks the boundary rule. All other scenarios apply new settings while reset is held, so the accumulator starts from zero and the cycle totals expected for R1 are exact.

// File: rtl/frac_baud_pkg.sv
`timescale 1ns/1ps
package frac_baud_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DIV_W  = 2 * BYTE_W;
  localparam int unsigned FRAC_W = 4;
  localparam int unsigned ACC_W  = FRAC_W + 1;
  localparam int unsigned PER_W  = DIV_W + 1;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [FRAC_W-1:0] mul;
    logic [FRAC_W-1:0] add;
  } baud_cfg_t;
endpackage

// File: rtl/baud_cfg_reg.sv
`timescale 1ns/1ps
module baud_cfg_reg
  import frac_baud_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  baud_cfg_t raw_i,
  output baud_cfg_t next_o,
  output logic      halt_o,
  output logic      err_o
);
  baud_cfg_t cfg_q;
  logic      loaded_q;
  logic [FRAC_W-1:0] mul_n;

  // normalise: mul 0 -> 1, add clamped to mul (max 50 % reduction)
  always_comb begin
    mul_n       = (raw_i.mul == '0) ? FRAC_W'(1) : raw_i.mul;
    next_o.div  = raw_i.div;
    next_o.mul  = mul_n;
    next_o.add  = (raw_i.add > mul_n) ? mul_n : raw_i.add;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      loaded_q <= 1'b0;
    end else if (load_i) begin
      cfg_q    <= next_o;
      loaded_q <= 1'b1;
    end
  end

  assign err_o  = loaded_q & ((cfg_q.div == '0) |
                              ((cfg_q.add != '0) & (cfg_q.div < DIV_W'(2))));
  assign halt_o = ~loaded_q | err_o;
endmodule

// File: rtl/baud_frac_acc.sv
`timescale 1ns/1ps
module baud_frac_acc
  import frac_baud_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [FRAC_W-1:0] mul_i,
  input  logic [FRAC_W-1:0] add_i,
  output logic              stretch_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum       = {1'b0, acc_q} + (ACC_W+1)'(add_i);
    stretch_o = sum >= (ACC_W+1)'(mul_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (step_i)  acc_q <= stretch_o ? ACC_W'(sum - (ACC_W+1)'(mul_i))
                                         : ACC_W'(sum);
  end
endmodule

// File: rtl/baud_period_ctr.sv
`timescale 1ns/1ps
module baud_period_ctr
  import frac_baud_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic             reload_i,
  input  logic             stretch_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             zero_o
);
  logic [PER_W-1:0] rem_q;
  logic [PER_W-1:0] base;

  assign base = {1'b0, div_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rem_q <= '0;
    else if (halt_i)   rem_q <= base - PER_W'(1);
    else if (reload_i) rem_q <= (stretch_i ? {div_i, 1'b0} : base) - PER_W'(1);
    else               rem_q <= rem_q - PER_W'(1);
  end

  assign zero_o = rem_q == '0;
endmodule

// File: rtl/baud_bit_ctr.sv
`timescale 1ns/1ps
module baud_bit_ctr #(
  parameter int unsigned OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic bit_o
);
  generate
    if (OVS <= 1) begin : g_pass
      assign bit_o = tick_i;
    end else begin : g_cnt
      localparam int unsigned CW = $clog2(OVS);
      localparam logic [CW-1:0] LAST = CW'(OVS - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (tick_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
      end
      assign bit_o = tick_i & (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/frac_baud_gen.sv
`timescale 1ns/1ps
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] div_lo_i,
  input  logic [BYTE_W-1:0] div_hi_i,
  input  logic [FRAC_W-1:0] mul_i,
  input  logic [FRAC_W-1:0] divadd_i,
  output logic              tick16_o,
  output logic              tick_bit_o,
  output logic              cfg_err_o
);
  baud_cfg_t raw, nxt;
  logic halt, zero, stretch, tick;

  assign raw  = '{div: {div_hi_i, div_lo_i}, mul: mul_i, add: divadd_i};
  assign tick = ~halt & zero;

  baud_cfg_reg i_cfg (
    .clk_i, .rst_ni,
    .load_i (halt | tick),
    .raw_i  (raw),
    .next_o (nxt),
    .halt_o (halt),
    .err_o  (cfg_err_o)
  );

  baud_frac_acc i_acc (
    .clk_i, .rst_ni,
    .clear_i   (halt),
    .step_i    (tick),
    .mul_i     (nxt.mul),
    .add_i     (nxt.add),
    .stretch_o (stretch)
  );

  baud_period_ctr i_per (
    .clk_i, .rst_ni,
    .halt_i    (halt),
    .reload_i  (tick),
    .stretch_i (stretch),
    .div_i     (nxt.div),
    .zero_o    (zero)
  );

  baud_bit_ctr #(.OVS(OVS)) i_bit (
    .clk_i, .rst_ni,
    .clear_i (halt),
    .tick_i  (tick),
    .bit_o   (tick_bit_o)
  );

  assign tick16_o = tick;
endmodule

// File: rtl/frac_baud_chk.sv
`timescale 1ns/1ps
module frac_baud_chk #(
  parameter int unsigned OVS = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] div_lo_i,
  input logic [7:0] div_hi_i,
  input logic [3:0] mul_i,
  input logic [3:0] divadd_i,
  input logic       tick16_o,
  input logic       tick_bit_o,
  input logic       cfg_err_o
);
  localparam int unsigned CW = (OVS > 1) ? $clog2(OVS) : 1;
  logic [15:0]   div;
  logic [CW-1:0] seen_q;

  assign div = {div_hi_i, div_lo_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_q <= '0;
    else if (cfg_err_o) seen_q <= '0;
    else if (tick16_o)  seen_q <= (seen_q == CW'(OVS - 1)) ? '0 : seen_q + CW'(1);
  end

  p_bit_with_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_bit_o |-> tick16_o);
  p_bit_every_16th_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick16_o |-> (tick_bit_o == (seen_q == CW'(OVS - 1))));
  p_bit_one_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_bit_o |=> !tick_bit_o);
  p_div1_every_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick16_o && div == 16'd1 && divadd_i == 4'd0) |=> tick16_o);
  p_min_div_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick16_o && divadd_i != 4'd0 && div < 16'd2) |=> cfg_err_o);
  p_zero_div_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick16_o && div == 16'd0) |=> cfg_err_o);
  p_quiet_on_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!tick16_o && !tick_bit_o));
  p_reset_quiet_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (!tick16_o && !tick_bit_o && !cfg_err_o));
endmodule

bind frac_baud_gen frac_baud_chk #(.OVS(OVS)) i_frac_baud_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .div_lo_i(div_lo_i), .div_hi_i(div_hi_i),
  .mul_i(mul_i), .divadd_i(divadd_i), .tick16_o(tick16_o),
  .tick_bit_o(tick_bit_o), .cfg_err_o(cfg_err_o)
);

// File: tb/test_frac_baud_gen.sv
`timescale 1ns/1ps
module test_frac_baud_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] div_lo_i = '0, div_hi_i = '0;
  logic [3:0] mul_i = '0, divadd_i = '0;
  logic       tick16_o, tick_bit_o, cfg_err_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  frac_baud_gen i_frac_baud_gen (.*);

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(int d, int m, int a);
    div_lo_i = d[7:0]; div_hi_i = d[15:8]; mul_i = m[3:0]; divadd_i = a[3:0];
  endtask

  task automatic restart(int d, int m, int a);
    @(negedge clk_i); rst_ni = 1'b0; set_cfg(d, m, a);
    @(negedge clk_i); @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic next_tick(output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!tick16_o && n < 5000);
  endtask

  task automatic t_reset;
    int n;
    @(negedge clk_i); rst_ni = 1'b0; set_cfg(5, 1, 0);
    @(negedge clk_i);
    check(!tick16_o && !tick_bit_o && !cfg_err_o, "R9 outputs low in reset",
          {tick16_o, tick_bit_o, cfg_err_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    next_tick(n);
    check(n == 5, "R9 first tick after D edges", n, 5);
    for (int i = 0; i < 3; i++) begin
      next_tick(n);
      check(n == 5, "R2 plain divide by 5", n, 5);
    end
  endtask

  task automatic t_div1;
    int n, t16;
    restart(1, 1, 0);
    do @(negedge clk_i); while (!tick_bit_o);
    check(tick16_o == 1, "R3 bit tick with 16x tick", tick16_o, 1);
    n = 0; t16 = 0;
    do begin
      @(negedge clk_i); n++;
      if (tick16_o) t16++;
      if (n == 1) check(tick_bit_o == 0, "R3 bit tick one cycle", tick_bit_o, 0);
    end while (!tick_bit_o && n < 100);
    check(n == 16, "R3 bit period with D=1", n, 16);
    check(t16 == 16, "R2 D=1 ticks every cycle", t16, 16);
  endtask

  task automatic t_total(int d, int m, int a, int groups, int exp, string req);
    int n, sum = 0;
    restart(d, m, a);
    next_tick(n);
    for (int i = 0; i < groups * ((m == 0) ? 1 : m); i++) begin
      next_tick(n); sum += n;
    end
    check(sum == exp, req, sum, exp);
  endtask

  task automatic t_each(int d, int m, int a, int exp, string req);
    int n;
    restart(d, m, a);
    next_tick(n);
    for (int i = 0; i < 3; i++) begin
      next_tick(n);
      check(n == exp, req, n, exp);
    end
  endtask

  task automatic t_err(int d, int m, int a, string req);
    int ticks = 0;
    restart(d, m, a);
    repeat (3) @(negedge clk_i);
    check(cfg_err_o == 1, req, cfg_err_o, 1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (tick16_o || tick_bit_o) ticks++;
    end
    check(ticks == 0, req, ticks, 0);
  endtask

  task automatic t_recover;
    int n;
    set_cfg(4, 1, 0);
    @(negedge clk_i);
    check(cfg_err_o == 0, "R8 halted reload next edge", cfg_err_o, 0);
    n = 1;
    while (!tick16_o && n < 100) begin @(negedge clk_i); n++; end
    check(n == 4, "R8 restart period after error", n, 4);
  endtask

  task automatic t_boundary;
    int n;
    restart(20, 1, 0);
    next_tick(n);
    repeat (5) @(negedge clk_i);
    set_cfg(3, 1, 0);
    next_tick(n);
    check(n == 15, "R8 running period keeps old divisor", n, 15);
    next_tick(n);
    check(n == 3, "R8 new divisor after boundary", n, 3);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_div1();
    t_total(4, 3, 1, 10, 160, "R1 D=4 M=3 A=1");
    t_total(7, 15, 4, 2, 266, "R1 D=7 M=15 A=4");
    t_each(2, 1, 1, 4, "R4 D=2 with add legal");
    t_each(3, 5, 5, 6, "R1 A=M halves rate");
    t_each(3, 2, 9, 6, "R7 add clamped to mul");
    t_each(3, 0, 1, 6, "R6 mul 0 acts as 1");
    t_each(3, 0, 0, 3, "R6 mul 0 add 0");
    t_each(258, 1, 0, 258, "R2 high byte divisor");
    t_err(1, 4, 2, "R4 D=1 with add");
    t_err(0, 4, 3, "R4 D=0 with add");
    t_err(0, 1, 0, "R5 D=0 plain");
    t_recover();
    t_boundary();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule